// File: doc/BRIEF.md
# Synchronous SRAM Read Output Pipeline

This block is the read side of a synchronous static RAM. Each rising clock edge may carry a command: when the address strobe is high, the chip enables decide between a read of the presented address and a deselect. A small internal word array answers reads through a registered read port. A mode input chooses one of two timings. In flow-through mode the array word goes straight to the data output. In pipelined mode it passes through one more rising-edge register, which costs one cycle of latency.

The drive enable follows the same pipeline as the data. A deselect moves down the select pipeline at the same depth as a read, so in pipelined mode the bus keeps showing the last read word for one full cycle after the deselect edge. It turns off only after the next edge. The output enable input is not clocked. It gates the drive enable directly, so the bus can be released in the middle of a cycle. A plain fill port loads words into the array.

Top module: `srp_read_pipe`

## Requirements
- R1: With `pipe_mode` = 0, a read sampled at a rising edge puts that address's word on `dq_out` and raises `dq_oe` just after the same edge (2-cycle first access counting the command cycle).
- R2: With `pipe_mode` = 1, a read sampled at a rising edge shows its word on `dq_out` with `dq_oe` high only after the following rising edge (3-cycle first access). After the command edge itself, `dq_oe` stays low when the pipeline was deselected.
- R3: Reads issued on consecutive edges produce one new word per cycle, in issue order, in both modes.
- R4: A deselect turns `dq_oe` off after the same number of edges a read needs to turn it on: the first edge in flow-through mode and the second edge in pipelined mode.
- R5: In pipelined mode, after a deselect edge that follows a read, `dq_oe` stays high for one full cycle and `dq_out` keeps the last read word. `dq_oe` goes low after the next rising edge.
- R6: `dq_oe` is the AND of the select state of the active stage and `out_en`. `out_en` acts without a clock edge.
- R7: The chip is selected only when `chip_en` equals the enable polarity vector (default 3'b011: bits 0 and 1 active high, bit 2 active low), sampled at an edge where `cmd_strobe` is high. A strobe with any other enable pattern is a deselect.
- R8: An edge with `cmd_strobe` low issues no command. The select state and `dq_out` keep their values, whatever `chip_en` is.
- R9: After synchronous reset, `dq_oe` stays low until a read has passed through the pipeline.
- R10: A word written through the fill port at an edge is returned by any later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined output register, 0 = flow-through |
| chip_en | input | NUM_CE (3) | Chip enables, polarity per bit set by CE_POL |
| cmd_strobe | input | 1 | Address strobe, qualifies a command at the edge |
| cmd_addr | input | ADDR_W (6) | Read address |
| out_en | input | 1 | Asynchronous output enable, active high |
| fill_en | input | 1 | Array load strobe |
| fill_addr | input | ADDR_W (6) | Array load address |
| fill_data | input | DATA_W (36) | Array load word |
| dq_out | output | DATA_W (36) | Read data bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Single reads from a deselected pipeline are run in each mode. They separate the flow-through timing from the pipelined timing by whether `dq_oe` rises one edge or two edges after the command. Streams of four reads on consecutive edges, followed by idle edges, show that a new word arrives each cycle and that idle edges hold the last word. A read followed by a deselect separates the pipelined deselect policy, which keeps the bus driven one more cycle, from an immediate turn-off. A toggle of `out_en` in mid-cycle, and strobes with each single enable bit inverted, check the asynchronous gate and the three-input select.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_DESEL = 2'd2
  } srp_cmd_e;
endpackage

// File: rtl/srp_cmd_decode.sv
module srp_cmd_decode
  import srp_pkg::*;
#(
  parameter int unsigned          NUM_CE = 3,
  parameter logic [NUM_CE-1:0]    CE_POL = 3'b011
) (
  input  logic              cmd_strobe,
  input  logic [NUM_CE-1:0] chip_en,
  output srp_cmd_e          cmd
);
  logic [NUM_CE-1:0] ce_ok;

  // Each enable is compared with its own polarity bit
  for (genvar i = 0; i < NUM_CE; i++) begin : g_ce
    if (CE_POL[i]) begin : g_hi
      assign ce_ok[i] = chip_en[i];
    end else begin : g_lo
      assign ce_ok[i] = ~chip_en[i];
    end
  end

  always_comb begin
    if (!cmd_strobe)  cmd = CMD_NONE;
    else if (&ce_ok)  cmd = CMD_READ;
    else              cmd = CMD_DESEL;
  end
endmodule

// File: rtl/srp_array.sv
module srp_array #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read port; holds its word between reads
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/srp_sel_pipe.sv
module srp_sel_pipe
  import srp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  srp_cmd_e cmd,
  output logic     sel_s1,
  output logic     sel_s2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_s1 <= 1'b0;
      sel_s2 <= 1'b0;
    end else begin
      case (cmd)
        CMD_READ:  sel_s1 <= 1'b1;
        CMD_DESEL: sel_s1 <= 1'b0;
        default:   sel_s1 <= sel_s1;
      endcase
      sel_s2 <= sel_s1;
    end
  end
endmodule

// File: rtl/srp_out_stage.sv
module srp_out_stage #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic              out_en,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              sel_s1,
  input  logic              sel_s2,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= arr_data;
  end

  // The mode picks the tap; out_en is left unclocked on purpose
  assign dq_out = pipe_mode ? out_q : arr_data;
  assign dq_oe  = (pipe_mode ? sel_s2 : sel_s1) & out_en;
endmodule

// File: rtl/srp_read_pipe.sv
module srp_read_pipe
  import srp_pkg::*;
#(
  parameter int unsigned       DATA_W = 36,
  parameter int unsigned       ADDR_W = 6,
  parameter int unsigned       NUM_CE = 3,
  parameter logic [NUM_CE-1:0] CE_POL = 3'b011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic [NUM_CE-1:0] chip_en,
  input  logic              cmd_strobe,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              out_en,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  srp_cmd_e          cmd;
  logic              sel_s1;
  logic              sel_s2;
  logic [DATA_W-1:0] arr_data;

  srp_cmd_decode #(.NUM_CE(NUM_CE), .CE_POL(CE_POL)) u_dec (
    .cmd_strobe (cmd_strobe),
    .chip_en    (chip_en),
    .cmd        (cmd)
  );

  srp_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_addr (fill_addr),
    .wr_data (fill_data),
    .rd_en   (cmd == CMD_READ),
    .rd_addr (cmd_addr),
    .rd_data (arr_data)
  );

  srp_sel_pipe u_sel (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .sel_s1 (sel_s1),
    .sel_s2 (sel_s2)
  );

  srp_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .pipe_mode (pipe_mode),
    .out_en    (out_en),
    .arr_data  (arr_data),
    .sel_s1    (sel_s1),
    .sel_s2    (sel_s2),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );
endmodule

// File: rtl/srp_read_pipe_chk.sv
module srp_read_pipe_chk #(
  parameter int unsigned       NUM_CE = 3,
  parameter logic [NUM_CE-1:0] CE_POL = 3'b011
) (
  input logic              clk,
  input logic              rst,
  input logic              pipe_mode,
  input logic [NUM_CE-1:0] chip_en,
  input logic              cmd_strobe,
  input logic              out_en,
  input logic              dq_oe,
  input logic              sel_s1,
  input logic              sel_s2
);
  p_flow_read_r1: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && cmd_strobe && chip_en == CE_POL) |=> (pipe_mode || dq_oe == out_en));

  p_desel_depth_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && chip_en != CE_POL) |=> ##1 !sel_s2);

  p_pipe_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && sel_s1 && cmd_strobe && chip_en != CE_POL)
      |=> (!pipe_mode || dq_oe == out_en));

  p_oe_gate_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> out_en);

  p_bad_ce_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && chip_en != CE_POL) |=> !sel_s1);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd_strobe |=> $stable(sel_s1));

  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !dq_oe);
endmodule

bind srp_read_pipe srp_read_pipe_chk #(.NUM_CE(NUM_CE), .CE_POL(CE_POL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pipe_mode  (pipe_mode),
  .chip_en    (chip_en),
  .cmd_strobe (cmd_strobe),
  .out_en     (out_en),
  .dq_oe      (dq_oe),
  .sel_s1     (sel_s1),
  .sel_s2     (sel_s2)
);

// File: tb/srp_read_pipe_tb.sv
module srp_read_pipe_tb;
  localparam int unsigned DW    = 36;
  localparam int unsigned AW    = 6;
  localparam int unsigned NCE   = 3;
  localparam logic [NCE-1:0] POL = 3'b011;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          pipe_mode;
  logic [NCE-1:0] chip_en;
  logic          cmd_strobe;
  logic [AW-1:0] cmd_addr;
  logic          out_en;
  logic          fill_en;
  logic [AW-1:0] fill_addr;
  logic [DW-1:0] fill_data;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  srp_read_pipe #(.DATA_W(DW), .ADDR_W(AW), .NUM_CE(NCE), .CE_POL(POL)) u_dut (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .chip_en(chip_en),
    .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr), .out_en(out_en),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] word_of(input int a);
    return DW'(a) * DW'(7919) + DW'(36'h123456789);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; each step crosses one rising edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_read(input int a);
    cmd_strobe = 1'b1; chip_en = POL; cmd_addr = AW'(a);
    step();
  endtask

  task automatic do_desel();
    cmd_strobe = 1'b1; chip_en = ~POL;
    step();
  endtask

  task automatic do_idle();
    cmd_strobe = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1; out_en = 1'b1; cmd_strobe = 1'b0; chip_en = POL;
    repeat (3) step();
    check("R9 oe during reset", 64'(dq_oe), 64'd0);
    rst = 1'b0;
    step();
    check("R9 oe after reset idle", 64'(dq_oe), 64'd0);
    pipe_mode = 1'b1;
    do_idle();
    check("R9 oe idle pipelined", 64'(dq_oe), 64'd0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < int'(DEPTH); i++) begin
      fill_en = 1'b1; fill_addr = AW'(i); fill_data = word_of(i);
      step();
    end
    fill_en = 1'b0;
  endtask

  task automatic t_flow_read();
    pipe_mode = 1'b0;
    do_desel();
    do_read(17);
    check("R1 flow oe", 64'(dq_oe), 64'd1);
    check("R1 R10 flow data", 64'(dq_out), 64'(word_of(17)));
    do_idle();
  endtask

  task automatic t_pipe_read();
    pipe_mode = 1'b1;
    do_desel(); do_desel();
    do_read(42);
    check("R2 pipe oe not yet", 64'(dq_oe), 64'd0);
    do_idle();
    check("R2 pipe oe", 64'(dq_oe), 64'd1);
    check("R2 R10 pipe data", 64'(dq_out), 64'(word_of(42)));
  endtask

  task automatic t_stream(input bit pm);
    int addrs [4] = '{5, 6, 40, 63};
    int lat = pm ? 1 : 0;
    pipe_mode = pm;
    do_desel(); do_desel();
    for (int k = 0; k < 7; k++) begin
      int idx;
      if (k < 4) do_read(addrs[k]);
      else       begin chip_en = ~POL; do_idle(); end
      idx = k - lat;
      if (idx < 0) begin
        check("R3 stream first not yet", 64'(dq_oe), 64'd0);
      end else if (idx < 4) begin
        check("R3 stream oe", 64'(dq_oe), 64'd1);
        check("R3 stream data", 64'(dq_out), 64'(word_of(addrs[idx])));
      end else begin
        check("R8 idle hold oe", 64'(dq_oe), 64'd1);
        check("R8 idle hold data", 64'(dq_out), 64'(word_of(addrs[3])));
      end
    end
  endtask

  task automatic t_deselect(input bit pm);
    pipe_mode = pm;
    do_desel(); do_desel();
    do_read(9);
    if (pm) do_idle();
    check("R4 drive before deselect", 64'(dq_oe), 64'd1);
    do_desel();
    if (pm) begin
      check("R5 pipe oe kept one cycle", 64'(dq_oe), 64'd1);
      check("R5 pipe last data kept", 64'(dq_out), 64'(word_of(9)));
      do_idle();
      check("R4 R5 pipe off after second edge", 64'(dq_oe), 64'd0);
    end else begin
      check("R4 flow off after first edge", 64'(dq_oe), 64'd0);
    end
  endtask

  task automatic t_oe_async();
    pipe_mode = 1'b0;
    do_read(33);
    check("R6 oe before drop", 64'(dq_oe), 64'd1);
    #1 out_en = 1'b0;
    #0.5;
    check("R6 oe follows out_en low", 64'(dq_oe), 64'd0);
    #0.5 out_en = 1'b1;
    #0.5;
    check("R6 oe follows out_en high", 64'(dq_oe), 64'd1);
    check("R6 data unchanged", 64'(dq_out), 64'(word_of(33)));
    step();
  endtask

  task automatic t_chip_sel();
    pipe_mode = 1'b0;
    for (int i = 0; i < int'(NCE); i++) begin
      do_read(20 + i);
      check("R7 selected read drives", 64'(dq_oe), 64'd1);
      cmd_strobe = 1'b0; chip_en = POL ^ NCE'(1 << i);
      step();
      check("R7 R8 bad enables without strobe ignored", 64'(dq_oe), 64'd1);
      cmd_strobe = 1'b1; cmd_addr = AW'(50);
      step();
      check("R7 one enable wrong deselects", 64'(dq_oe), 64'd0);
    end
    cmd_strobe = 1'b0; chip_en = POL;
  endtask

  initial begin
    pipe_mode = 1'b0; chip_en = POL; cmd_strobe = 1'b0; cmd_addr = '0;
    out_en = 1'b1; fill_en = 1'b0; fill_addr = '0; fill_data = '0; rst = 1'b1;
    step();
    t_reset();
    t_fill();
    t_flow_read();
    t_pipe_read();
    t_stream(1'b0);
    t_stream(1'b1);
    t_deselect(1'b0);
    t_deselect(1'b1);
    t_oe_async();
    t_chip_sel();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule